// File: doc/BRIEF.md
# Sequential Instruction Prefetch Buffer

This block sits on the miss path of an instruction cache, between the cache and the next memory level. Each accepted miss becomes a request for a pair of consecutive cache lines. The first line that comes back refills the missing line. The second line is parked in a one-line buffer together with its line address. If the cache later misses on exactly that line, the block serves the refill from the buffer with no wait on memory.

After such a buffer hit, the block at once requests the next pair of lines. It keeps the line that follows the one just served. A miss that does not match the buffered line drops it and starts a fresh pair request.

Only one memory request is in flight at a time, and the miss port is held off until that request has fully returned. A flush input discards the buffered line and any data still due for a pending request. Redirects and invalidations use this flush. Addresses on every port are line addresses, and the line after the highest address is line 0.

Top module: `ifetch_pfb`

## Requirements
- R1: After reset, miss_ready_o is 1, refill_valid_o is 0, mem_req_valid_o is 0 and the buffer holds no line.
- R2: A miss that does not hit the buffer raises mem_req_valid_o with mem_req_addr_o equal to the miss address. The request and its address stay unchanged until mem_req_ready_i is seen high.
- R3: The first response beat of a demand request drives refill_valid_o high for exactly one cycle, starting the cycle after the beat. In that cycle refill_addr_o is the miss address and refill_data_o is the beat data.
- R4: The second beat of a demand request produces no refill. It is stored as line (miss address + 1). A later miss on that line is refilled from the buffer one cycle after the miss is accepted.
- R5: A buffer hit consumes the buffered line. Repeating the miss on the same address later goes to memory.
- R6: A buffer hit at line H issues a pair request at H+1. Its first beat is stored as line H+1, its second beat is discarded, and neither beat produces a refill.
- R7: A miss that does not match the buffered line drops it. A later miss on the dropped line goes to memory.
- R8: A flush_i pulse while idle empties the buffer.
- R9: After flush_i is seen high while a request is pending, the remaining beats of that request produce no refill and no buffer fill. No refill appears in the cycle after flush_i is high.
- R10: miss_ready_o is 0 from the cycle after a miss is accepted until the cycle after the second beat of its request. It is also 0 in any cycle with flush_i high, and while mem_req_valid_o is high.
- R11: Line addresses wrap. A miss on the highest line buffers line 0, and a miss on line 0 then hits the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Drop the buffered line and the data of any pending request |
| miss_valid_i | input | 1 | Cache presents a miss |
| miss_addr_i | input | ADDR_W | Line address of the miss |
| miss_ready_o | output | 1 | Miss accepted when high together with miss_valid_i |
| refill_valid_o | output | 1 | One-cycle refill strobe to the cache |
| refill_addr_o | output | ADDR_W | Line address being refilled |
| refill_data_o | output | LINE_W | Refill line data |
| mem_req_valid_o | output | 1 | Pair request to memory |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | ADDR_W | First line of the requested pair |
| mem_rsp_valid_i | input | 1 | One response beat (one line) |
| mem_rsp_data_i | input | LINE_W | Response beat data |

## Verification
The assertions assume that memory returns exactly two beats for each accepted request, in line order, never before the request handshake and never without a request. They also assume the cache keeps miss_valid_i up until the miss is accepted. The bench acts as that memory. It answers every request with exactly two beats, one at a time, and only after the request has been granted. It sometimes stalls the grant, which exercises the hold rule of the request. It drops miss_valid_i as soon as the miss is accepted. Flushes are issued only while idle, or between a granted request and its beats.

// File: rtl/ifpb_pkg.sv
package ifpb_pkg;
  localparam int unsigned PAIR_BEATS = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_BEAT0 = 2'd2,
    ST_BEAT1 = 2'd3
  } ifpb_state_e;
endpackage

// File: rtl/ifpb_line_buf.sv
module ifpb_line_buf #(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned LINE_W = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [LINE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  output logic              hit_o,
  output logic [LINE_W-1:0] data_o
);
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    valid_q <= 1'b0;
    else if (clr_i) valid_q <= 1'b0;
    else if (wr_i)  valid_q <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && !clr_i) begin
      addr_q <= wr_addr_i;
      data_q <= wr_data_i;
    end
  end

  assign hit_o  = valid_q && (addr_q == lookup_addr_i);
  assign data_o = data_q;
endmodule

// File: rtl/ifpb_ctrl.sv
module ifpb_ctrl
  import ifpb_pkg::*;
#(
  parameter int unsigned ADDR_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              miss_valid_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  output logic              miss_ready_o,
  input  logic              buf_hit_i,
  output logic              buf_clr_o,
  output logic              buf_wr_o,
  output logic [ADDR_W-1:0] buf_wr_addr_o,
  output logic              fill_mem_o,
  output logic              fill_buf_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  input  logic              mem_rsp_valid_i
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  ifpb_state_e       state_q, state_d;
  logic [ADDR_W-1:0] req_addr_q;
  logic              prefetch_q, flushed_q;
  logic              accept, beat, keep, in_beat0, in_beat1;

  assign miss_ready_o = (state_q == ST_IDLE) && !flush_i;
  assign accept       = miss_valid_i && miss_ready_o;
  assign in_beat0     = (state_q == ST_BEAT0);
  assign in_beat1     = (state_q == ST_BEAT1);
  assign beat         = mem_rsp_valid_i && (in_beat0 || in_beat1);
  // beats of a flushed request are dropped, including one meeting the flush
  assign keep         = beat && !flushed_q && !flush_i;

  assign buf_clr_o     = flush_i || accept;
  assign fill_buf_o    = accept && buf_hit_i;
  assign fill_mem_o    = keep && in_beat0 && !prefetch_q;
  assign buf_wr_o      = keep && ((in_beat0 && prefetch_q) || (in_beat1 && !prefetch_q));
  assign buf_wr_addr_o = in_beat1 ? req_addr_q + ONE : req_addr_q;
  assign req_addr_o      = req_addr_q;
  assign mem_req_valid_o = (state_q == ST_REQ);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept)          state_d = ST_REQ;
      ST_REQ:   if (mem_req_ready_i) state_d = ST_BEAT0;
      ST_BEAT0: if (mem_rsp_valid_i) state_d = ST_BEAT1;
      ST_BEAT1: if (mem_rsp_valid_i) state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      req_addr_q <= '0;
      prefetch_q <= 1'b0;
      flushed_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        req_addr_q <= buf_hit_i ? miss_addr_i + ONE : miss_addr_i;
        prefetch_q <= buf_hit_i;
        flushed_q  <= 1'b0;
      end else if (flush_i && state_q != ST_IDLE) begin
        flushed_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ifpb_refill_reg.sv
module ifpb_refill_reg #(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned LINE_W = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_mem_i,
  input  logic              fill_buf_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [LINE_W-1:0] mem_data_i,
  input  logic [ADDR_W-1:0] buf_addr_i,
  input  logic [LINE_W-1:0] buf_data_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LINE_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= fill_mem_i || fill_buf_i;
      if (fill_buf_i) begin
        addr_o <= buf_addr_i;
        data_o <= buf_data_i;
      end else if (fill_mem_i) begin
        addr_o <= mem_addr_i;
        data_o <= mem_data_i;
      end
    end
  end
endmodule

// File: rtl/ifetch_pfb.sv
module ifetch_pfb #(
  parameter int unsigned ADDR_W     = 26,
  parameter int unsigned LINE_BYTES = 32,
  localparam int unsigned LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              miss_valid_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  output logic              miss_ready_o,
  output logic              refill_valid_o,
  output logic [ADDR_W-1:0] refill_addr_o,
  output logic [LINE_W-1:0] refill_data_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [LINE_W-1:0] mem_rsp_data_i
);
  logic              buf_hit, buf_clr, buf_wr, fill_mem, fill_buf;
  logic [ADDR_W-1:0] buf_wr_addr, req_addr;
  logic [LINE_W-1:0] buf_data;

  ifpb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .flush_i         (flush_i),
    .miss_valid_i    (miss_valid_i),
    .miss_addr_i     (miss_addr_i),
    .miss_ready_o    (miss_ready_o),
    .buf_hit_i       (buf_hit),
    .buf_clr_o       (buf_clr),
    .buf_wr_o        (buf_wr),
    .buf_wr_addr_o   (buf_wr_addr),
    .fill_mem_o      (fill_mem),
    .fill_buf_o      (fill_buf),
    .req_addr_o      (req_addr),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i)
  );

  ifpb_line_buf #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_buf (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         (buf_clr),
    .wr_i          (buf_wr),
    .wr_addr_i     (buf_wr_addr),
    .wr_data_i     (mem_rsp_data_i),
    .lookup_addr_i (miss_addr_i),
    .hit_o         (buf_hit),
    .data_o        (buf_data)
  );

  ifpb_refill_reg #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_refill (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fill_mem_i (fill_mem),
    .fill_buf_i (fill_buf),
    .mem_addr_i (req_addr),
    .mem_data_i (mem_rsp_data_i),
    .buf_addr_i (miss_addr_i),
    .buf_data_i (buf_data),
    .valid_o    (refill_valid_o),
    .addr_o     (refill_addr_o),
    .data_o     (refill_data_o)
  );

  assign mem_req_addr_o = req_addr;
endmodule

// File: rtl/ifpb_checker.sv
module ifpb_checker #(
  parameter int unsigned ADDR_W = 26
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              miss_valid_i,
  input logic              miss_ready_o,
  input logic              refill_valid_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o
);
  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  assert_refill_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_valid_o |=> !refill_valid_o);

  assert_flush_no_refill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !refill_valid_o);

  assert_single_outstanding_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !miss_ready_o);

  assert_accept_closes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_i && miss_ready_o |=> !miss_ready_o);

  assert_flush_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !miss_ready_o);
endmodule

bind ifetch_pfb ifpb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .flush_i         (flush_i),
  .miss_valid_i    (miss_valid_i),
  .miss_ready_o    (miss_ready_o),
  .refill_valid_o  (refill_valid_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o)
);

// File: tb/ifetch_pfb_test.sv
`timescale 1ns/1ps
module ifetch_pfb_test;
  localparam int AW = 26;
  localparam int LW = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          miss_valid = 1'b0;
  logic [AW-1:0] miss_addr = '0;
  logic          miss_ready, refill_valid, req_valid;
  logic [AW-1:0] refill_addr, req_addr;
  logic [LW-1:0] refill_data;
  logic          req_ready = 1'b0;
  logic          rsp_valid = 1'b0;
  logic [LW-1:0] rsp_data = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic          rf_v;
  logic [AW-1:0] rf_a;
  logic [LW-1:0] rf_d;

  always #5 clk = ~clk;

  ifetch_pfb #(.ADDR_W(AW), .LINE_BYTES(LW/8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .miss_valid_i(miss_valid), .miss_addr_i(miss_addr), .miss_ready_o(miss_ready),
    .refill_valid_o(refill_valid), .refill_addr_o(refill_addr), .refill_data_o(refill_data),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready), .mem_req_addr_o(req_addr),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data)
  );

  function automatic logic [LW-1:0] line(input logic [31:0] s);
    return {8{s ^ 32'h5a00_0000}};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic capture();
    rf_v = refill_valid; rf_a = refill_addr; rf_d = refill_data;
  endtask

  // tasks start and end just after a falling edge
  task automatic miss(input logic [AW-1:0] a);
    miss_valid = 1'b1; miss_addr = a;
    #1;
    while (!miss_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    miss_valid = 1'b0;
    #1; capture();
  endtask

  task automatic serve_req(input logic [AW-1:0] exp_a, input string req, input int stall);
    int n = 0;
    while (!req_valid && n < 20) begin @(negedge clk); #1; n++; end
    chk(req_valid && req_addr == exp_a, req, "request address", LW'(req_addr), LW'(exp_a));
    chk(!miss_ready, "R10", "ready while request pending", LW'(miss_ready), 0);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk); #1;
      chk(req_valid && req_addr == exp_a, "R2", "request held under stall", LW'(req_addr), LW'(exp_a));
    end
    req_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic beat(input logic [LW-1:0] d);
    rsp_valid = 1'b1; rsp_data = d;
    @(posedge clk); @(negedge clk);
    rsp_valid = 1'b0;
    #1; capture();
  endtask

  task automatic expect_refill(input string req, input logic [AW-1:0] a, input logic [LW-1:0] d);
    chk(rf_v == 1'b1, req, "refill valid", LW'(rf_v), 1);
    chk(rf_a == a, req, "refill address", LW'(rf_a), LW'(a));
    chk(rf_d == d, req, "refill data", rf_d, d);
  endtask

  task automatic expect_none(input string req);
    chk(rf_v == 1'b0, req, "no refill", LW'(rf_v), 0);
  endtask

  task automatic flush_pulse();
    flush = 1'b1; #1;
    chk(!miss_ready, "R10", "ready during flush", LW'(miss_ready), 0);
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk(miss_ready == 1'b1, "R1", "ready after reset", LW'(miss_ready), 1);
    chk(refill_valid == 1'b0, "R1", "refill after reset", LW'(refill_valid), 0);
    chk(req_valid == 1'b0, "R1", "request after reset", LW'(req_valid), 0);
  endtask

  task automatic t_demand();
    miss(26'd100);
    expect_none("R3");
    serve_req(26'd100, "R2", 2);
    beat(line(1));
    expect_refill("R3", 26'd100, line(1));
    chk(!miss_ready, "R10", "ready between beats", LW'(miss_ready), 0);
    beat(line(2));
    expect_none("R4");
    chk(miss_ready, "R10", "ready after last beat", LW'(miss_ready), 1);
  endtask

  task automatic t_hit_prefetch();
    miss(26'd101);
    expect_refill("R4", 26'd101, line(2));
    serve_req(26'd102, "R6", 0);
    beat(line(3)); expect_none("R6");
    beat(line(4)); expect_none("R6");
    miss(26'd102);
    expect_refill("R6", 26'd102, line(3));
    serve_req(26'd103, "R6", 1);
    beat(line(5)); beat(line(6));
  endtask

  task automatic t_repeat();
    miss(26'd102);
    expect_none("R5");
    serve_req(26'd102, "R5", 0);
    beat(line(7)); expect_refill("R5", 26'd102, line(7));
    beat(line(8));
  endtask

  task automatic t_mismatch();
    miss(26'd500);
    expect_none("R7");
    serve_req(26'd500, "R7", 0);
    beat(line(9)); beat(line(10));
    miss(26'd103);
    expect_none("R7");
    serve_req(26'd103, "R7", 0);
    beat(line(11)); expect_refill("R7", 26'd103, line(11));
    beat(line(12));
  endtask

  task automatic t_flush_idle();
    flush_pulse();
    miss(26'd104);
    expect_none("R8");
    serve_req(26'd104, "R8", 0);
    beat(line(13)); beat(line(14));
  endtask

  task automatic t_flush_pending();
    miss(26'd105);
    expect_refill("R9", 26'd105, line(14));
    serve_req(26'd106, "R9", 0);
    flush_pulse();
    beat(line(15)); expect_none("R9");
    beat(line(16)); expect_none("R9");
    chk(miss_ready, "R10", "ready after flushed request", LW'(miss_ready), 1);
    miss(26'd106);
    expect_none("R9");
    serve_req(26'd106, "R9", 0);
    flush_pulse();
    beat(line(17)); expect_none("R9");
    beat(line(18)); expect_none("R9");
    miss(26'd107);
    expect_none("R9");
    serve_req(26'd107, "R9", 0);
    beat(line(19)); expect_refill("R9", 26'd107, line(19));
    beat(line(20));
  endtask

  task automatic t_wrap();
    miss({AW{1'b1}});
    serve_req({AW{1'b1}}, "R11", 0);
    beat(line(21)); expect_refill("R11", {AW{1'b1}}, line(21));
    beat(line(22));
    miss(26'd0);
    expect_refill("R11", 26'd0, line(22));
    serve_req(26'd1, "R11", 0);
    beat(line(23)); beat(line(24));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_demand();
    t_hit_prefetch();
    t_repeat();
    t_mismatch();
    t_flush_idle();
    t_flush_pending();
    t_wrap();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule